// File: doc/BRIEF.md
# Prescaled Down-Counting Core Timer

This block is a word-addressed timer with four 32-bit registers. Software loads a start count and a reload period, and chooses a prescale divisor. Setting the power and run bits in the control register starts the timer. On every prescaled tick the count drops by one. When a tick would take the count from 1 to 0 (or the count is already 0), the timer expires. Expiry sets a status bit in the control register and raises the interrupt output for one cycle.

After expiry the timer has two modes. With auto-reload set, the count is loaded again from the period register and the timer keeps running. With auto-reload clear, the count stays at 0 and the timer halts until software writes the control, period or count register. The count register always reads the live value. A write to the period register is also copied into the count.

Top module: `core_tmr`

## Requirements
- R1: After reset, all four registers read 0 and the interrupt output is low.
- R2: The address bits [3:2] pick a register: 0 is control, 1 is period, 2 is scale, 3 is count. Control bit 0 is power, bit 1 is run, bit 2 is auto-reload and bit 3 is the interrupt status. Control bits above 3 read 0. Period and scale read back the full written word.
- R3: The count changes only while both control bit 0 and control bit 1 are 1. With either bit clear, the count holds and no interrupt is raised.
- R4: The divisor is scale[7:0]+1. The first decrement lands divisor cycles after the enabling write, and later decrements follow every divisor cycles. Scale bits above 7 have no effect.
- R5: Expiry happens on the tick seen with a count of 1 or 0. In the cycle after that tick, control bit 3 reads 1 and the interrupt output is high for that one cycle.
- R6: With auto-reload set, expiry loads the period value into the count and counting continues.
- R7: With auto-reload clear, expiry leaves the count at 0 and the timer halts with no further interrupts. A write to control, period or count restarts it.
- R8: A period write stores the same value into the count register.
- R9: Period and count writes take effect while the timer runs, and counting continues from the new value.
- R10: The interrupt status bit is plain read/write. Writing 0 clears it, writing 1 sets it, and neither write raises the interrupt output.
- R11: A scale write while running leaves the current prescale period and the count untouched. The new divisor applies from the next period onward.
- R12: The prescaler restarts from zero whenever the timer goes from stopped to running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Word write strobe |
| addr_i | input | 2 | Byte address bits [3:2] (register select) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register, combinational |
| irq_o | output | 1 | One-cycle pulse on each expiry |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and an 8-bit prescale field. Small scale values (0, 1 and 3) keep tick spacing short, so each decrement can be pinned to an exact cycle. With small periods and counts, expiry, reload, halt and restart all happen within a few dozen cycles. One scale write sets bits above bit 7, to show that only the low byte sets the divisor.

// File: rtl/core_tmr_pkg.sv
package core_tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_SCALE  = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CB_PWR = 0;
  localparam int unsigned CB_RUN = 1;
  localparam int unsigned CB_AR  = 2;
  localparam int unsigned CB_INT = 3;
  localparam int unsigned CTRL_W = 4;
endpackage

// File: rtl/core_tmr_regs.sv
module core_tmr_regs
  import core_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] period_o,
  output logic [DATA_W-1:0] scale_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] period_q, scale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '0;
      scale_q  <= '0;
    end else begin
      if (wr_en_i && sel_i == SEL_CTRL)   ctrl_q   <= wdata_i[CTRL_W-1:0];
      if (wr_en_i && sel_i == SEL_PERIOD) period_q <= wdata_i;
      if (wr_en_i && sel_i == SEL_SCALE)  scale_q  <= wdata_i;
      // expiry wins over a same-cycle control write on the status bit
      if (expire_i) ctrl_q[CB_INT] <= 1'b1;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;
  assign scale_o  = scale_q;
endmodule

// File: rtl/core_tmr_presc.sv
module core_tmr_presc #(
  parameter int unsigned PS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PS_W-1:0] scale_i,
  output logic            tick_o
);
  logic [PS_W-1:0] pcnt_q, lim_q;

  assign tick_o = run_i && (pcnt_q == lim_q);

  // limit is latched per period so a scale write applies from the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      lim_q  <= '0;
    end else if (!run_i || tick_o) begin
      pcnt_q <= '0;
      lim_q  <= scale_i;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/core_tmr_cnt.sv
module core_tmr_cnt #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_per_i,
  input  logic              wr_cnt_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] period_i,
  input  logic              autoreload_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              halt_o,
  output logic              expire_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              halt_q, irq_q;

  assign expire_o = tick_i && (cnt_q <= DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= expire_o;
      if (wr_per_i || wr_cnt_i) cnt_q <= wdata_i;
      else if (expire_o)        cnt_q <= autoreload_i ? period_i : '0;
      else if (tick_i)          cnt_q <= cnt_q - 1'b1;
      if (wr_ctrl_i || wr_per_i || wr_cnt_i) halt_q <= 1'b0;
      else if (expire_o && !autoreload_i)    halt_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign halt_o = halt_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/core_tmr.sv
module core_tmr
  import core_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:2]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] period, scale, cnt;
  logic              halt, expire, tick, run;

  assign sel = reg_sel_e'(addr_i);
  assign run = ctrl[CB_PWR] && ctrl[CB_RUN] && !halt;

  core_tmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .sel_i(sel), .wdata_i,
    .expire_i(expire), .ctrl_o(ctrl), .period_o(period), .scale_o(scale)
  );

  core_tmr_presc #(.PS_W(PS_W)) u_presc (
    .clk_i, .rst_ni, .run_i(run), .scale_i(scale[PS_W-1:0]), .tick_o(tick)
  );

  core_tmr_cnt #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick),
    .wr_ctrl_i(wr_en_i && sel == SEL_CTRL),
    .wr_per_i (wr_en_i && sel == SEL_PERIOD),
    .wr_cnt_i (wr_en_i && sel == SEL_COUNT),
    .wdata_i, .period_i(period), .autoreload_i(ctrl[CB_AR]),
    .cnt_o(cnt), .halt_o(halt), .expire_o(expire), .irq_o
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rdata_o = DATA_W'(ctrl);
      SEL_PERIOD: rdata_o = period;
      SEL_SCALE:  rdata_o = scale;
      default:    rdata_o = cnt;
    endcase
  end
endmodule

// File: rtl/core_tmr_chk.sv
module core_tmr_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [3:2]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [3:0]        ctrl,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] period,
  input logic              halt
);
  p_irq_sets_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl[3]);

  p_stopped_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ctrl[0] && ctrl[1]) && !wr_en_i) |=> ($stable(cnt) && !irq_o));

  p_period_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (cnt == $past(wdata_i) && period == $past(wdata_i)));

  p_expiry_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(!wr_en_i)) |-> (cnt == (ctrl[2] ? period : '0)));

  p_halt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !wr_en_i) |=> ($stable(cnt) && !irq_o));
endmodule

bind core_tmr core_tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .irq_o,
  .ctrl(ctrl), .cnt(cnt), .period(period), .halt(halt)
);

// File: tb/core_tmr_tb_top.sv
module core_tmr_tb_top;
  localparam logic [1:0] A_CTRL = 2'd0, A_PER = 2'd1, A_SCL = 2'd2, A_CNT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  core_tmr dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_layout;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFF4);
    rd(A_CTRL, v); chk("R2 ctrl width", v, 32'h4);
    wr(A_PER, 32'hDEAD_BEEF);
    rd(A_PER, v); chk("R2 period readback", v, 32'hDEAD_BEEF);
    wr(A_SCL, 32'h1234_5600);
    rd(A_SCL, v); chk("R2 scale readback", v, 32'h1234_5600);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    wr(A_SCL, 0); wr(A_CNT, 20);
    wr(A_CTRL, 32'h1); idle(8);
    rd(A_CNT, v); chk("R3 power only", v, 20);
    wr(A_CTRL, 32'h2); idle(8);
    rd(A_CNT, v); chk("R3 run only", v, 20);
    chk("R3 no irq", {31'b0, irq}, 0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(A_CNT, 10); wr(A_SCL, 32'h0001_FF03);
    wr(A_CTRL, 32'h3);
    idle(8);  rd(A_CNT, v); chk("R4 two ticks", v, 8);
    idle(3);  rd(A_CNT, v); chk("R4 between ticks", v, 8);
    idle(1);  rd(A_CNT, v); chk("R4 third tick", v, 7);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(A_SCL, 1); wr(A_PER, 3);
    rd(A_CNT, v); chk("R8 period mirrored", v, 3);
    wr(A_CTRL, 32'h7);
    idle(5); rd(A_CNT, v); chk("R6 before expiry", v, 1);
    chk("R5 no early irq", {31'b0, irq}, 0);
    idle(1); rd(A_CNT, v); chk("R6 reloaded", v, 3);
    chk("R5 irq pulse", {31'b0, irq}, 1);
    rd(A_CTRL, v); chk("R5 status set", v, 32'hF);
    idle(1); chk("R5 irq one cycle", {31'b0, irq}, 0);
    rd(A_CNT, v); chk("R6 keeps running", v, 3);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R10 status cleared", v, 0);
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v); chk("R10 status set by write", v, 32'h8);
    chk("R10 no irq from write", {31'b0, irq}, 0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    int pulses;
    wr(A_SCL, 0); wr(A_CNT, 2);
    wr(A_CTRL, 32'h3);
    idle(2); rd(A_CNT, v); chk("R7 count zero", v, 0);
    chk("R5 one-shot irq", {31'b0, irq}, 1);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      idle(1); if (irq) pulses++;
    end
    chk("R7 halted no irq", pulses, 0);
    rd(A_CNT, v); chk("R7 halted count", v, 0);
    wr(A_CNT, 1);
    idle(1); chk("R7 restart expiry", {31'b0, irq}, 1);
    wr(A_CTRL, 32'h0); wr(A_CNT, 0);
    wr(A_CTRL, 32'h3);
    idle(1); chk("R5 zero count expires", {31'b0, irq}, 1);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_live_write;
    logic [31:0] v;
    wr(A_SCL, 0); wr(A_PER, 100);
    wr(A_CTRL, 32'h7);
    idle(5); rd(A_CNT, v); chk("R9 running", v, 95);
    wr(A_CNT, 50);
    idle(3); rd(A_CNT, v); chk("R9 count write live", v, 47);
    wr(A_PER, 20);
    idle(2); rd(A_CNT, v); chk("R9 period write live", v, 18);
    rd(A_PER, v); chk("R9 period stored", v, 20);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_scale_change;
    logic [31:0] v;
    wr(A_CNT, 100); wr(A_SCL, 3);
    wr(A_CTRL, 32'h3);
    idle(5); rd(A_CNT, v); chk("R11 first tick", v, 99);
    wr(A_SCL, 0);
    rd(A_CNT, v); chk("R11 count kept", v, 99);
    idle(1); rd(A_CNT, v); chk("R11 old period runs", v, 99);
    idle(1); rd(A_CNT, v); chk("R11 old period ends", v, 98);
    idle(2); rd(A_CNT, v); chk("R11 new divisor", v, 96);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_restart;
    logic [31:0] v, base;
    wr(A_CNT, 50); wr(A_SCL, 3);
    wr(A_CTRL, 32'h3);
    idle(2);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, base);
    wr(A_CTRL, 32'h3);
    idle(3); rd(A_CNT, v); chk("R12 prescaler restarted", v, base);
    idle(1); rd(A_CNT, v); chk("R12 full period", v, base - 1);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    #100_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_gate();
    t_prescale();
    t_reload();
    t_oneshot();
    t_live_write();
    t_scale_change();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule